// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by reading a two-level page table in memory. The virtual address has three fields. The top 10 bits index a first-level (directory) table. The next 10 bits index a second-level table. The low 12 bits are the offset inside a 4 KB page. The directory table starts at the address held on the `table_base` input, which is captured when a request is accepted. The directory entry names the 4 KB-aligned second-level table. The second-level entry gives the frame, and the frame is joined with the unchanged offset to form the result.

The walker has one memory read port. It issues the directory read first and then the second-level read, because the second address depends on the first result. It waits as long as needed for each read to return. Every table entry is a 32-bit word. Bits [31:12] hold a frame number and bit 0 is the present flag. Bits [11:1] are ignored by the walker. A cleared present flag at either level ends the walk with a fault, and the fault output names the level where the walk stopped.

The controller has five states:
- `ST_IDLE`: waits for a request. `ST_IDLE -> ST_OUTER` happens on `req_valid`.
- `ST_OUTER`: reads the directory entry. On a returned present entry it moves `ST_OUTER -> ST_INNER`. On a non-present entry it moves `ST_OUTER -> ST_FAULT`.
- `ST_INNER`: reads the second-level entry. On a present entry it moves `ST_INNER -> ST_DONE`. Otherwise it moves `ST_INNER -> ST_FAULT`.
- `ST_DONE` and `ST_FAULT`: each lasts one cycle and returns to `ST_IDLE`.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req` and `resp_valid` are 0.
- R2: The first read of a walk goes to `table_base + vaddr[31:22]*4`. `table_base` is sampled when the request is accepted.
- R3: After a present directory entry, the second read goes to `{entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: `mem_req` stays high, and `mem_addr` stays unchanged, until the cycle in which `mem_rvalid` is high.
- R5: A walk with both entries present responds in the cycle after the second read returns. The response has `resp_valid`=1, `resp_fault`=0 and `resp_paddr = {second_entry[31:12], vaddr[11:0]}`.
- R6: If the directory entry has bit 0 = 0, the walk responds in the next cycle with `resp_fault`=1 and `resp_fault_level`=0 (0 means the directory level). No second read is made and `resp_paddr` is 0.
- R7: If the second-level entry has bit 0 = 0, the walk responds with `resp_fault`=1 and `resp_fault_level`=1 (1 means the second level), and `resp_paddr` is 0.
- R8: `req_ready` is 1 only in `ST_IDLE`. A `req_valid` raised during a walk is ignored and does not change that walk's result.
- R9: `resp_valid` lasts exactly one cycle, and the next cycle `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| table_base | input | 32 | Byte address of the directory table |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| mem_req | output | 1 | Memory read outstanding |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Translated physical address (0 on fault) |
| resp_fault | output | 1 | Walk ended on a non-present entry |
| resp_fault_level | output | 1 | Level of the fault: 0 = directory, 1 = second level |

## Verification
The first read address appears in the cycle after the request edge. Each later read address appears in the cycle after the previous `mem_rvalid` edge. The response appears one cycle after the last returned read, and it is gone one cycle later. The bench drives inputs on falling edges and samples outputs on falling edges. It steps one edge at a time through this schedule, so each check lands in the exact cycle a value is due. Read latency varies from zero to five cycles across the vectors, and the hold of the request and its address is checked in every waiting cycle.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    localparam logic LVL_DIR  = 1'b0;
    localparam logic LVL_LEAF = 1'b1;
endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic [VA_W-1:0]       base,
    input  logic [VA_W-1:0]       vaddr,
    input  logic [VA_W-OFF_W-1:0] leaf_table_frame,
    output logic [VA_W-1:0]       dir_entry_addr,
    output logic [VA_W-1:0]       leaf_entry_addr
);
    localparam int PTE_SH = $clog2(PTE_BYTES);

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] leaf_idx;

    assign dir_idx  = vaddr[VA_W-1 -: IDX_W];
    assign leaf_idx = vaddr[OFF_W +: IDX_W];

    assign dir_entry_addr  = base + (VA_W'(dir_idx) << PTE_SH);
    assign leaf_entry_addr = {leaf_table_frame, {OFF_W{1'b0}}} + (VA_W'(leaf_idx) << PTE_SH);
endmodule

// File: rtl/pgwalk_pte_decode.sv
module pgwalk_pte_decode #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]       entry,
    output logic [VA_W-OFF_W-1:0] frame,
    output logic                  present
);
    assign frame   = entry[VA_W-1:OFF_W];
    assign present = entry[0];
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] table_base,
    output logic            req_ready,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata,
    output logic            resp_valid,
    output logic [VA_W-1:0] resp_paddr,
    output logic            resp_fault,
    output logic            resp_fault_level
);
    import pgwalk_pkg::*;

    localparam int FRAME_W = VA_W - OFF_W;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]    vaddr_q;
    logic [VA_W-1:0]    base_q;
    logic [FRAME_W-1:0] leaf_frame_q;
    logic [VA_W-1:0]    paddr_q;
    logic               level_q;

    logic [FRAME_W-1:0] rd_frame;
    logic               rd_present;
    logic [VA_W-1:0]    dir_addr;
    logic [VA_W-1:0]    leaf_addr;

    pgwalk_addr_gen #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)
    ) addr_i (
        .base            (base_q),
        .vaddr           (vaddr_q),
        .leaf_table_frame(leaf_frame_q),
        .dir_entry_addr  (dir_addr),
        .leaf_entry_addr (leaf_addr)
    );

    pgwalk_pte_decode #(
        .VA_W(VA_W), .OFF_W(OFF_W)
    ) dec_i (
        .entry  (mem_rdata),
        .frame  (rd_frame),
        .present(rd_present)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)  state_d = ST_OUTER;
            ST_OUTER: if (mem_rvalid) state_d = rd_present ? ST_INNER : ST_FAULT;
            ST_INNER: if (mem_rvalid) state_d = rd_present ? ST_DONE  : ST_FAULT;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q      <= '0;
            base_q       <= '0;
            leaf_frame_q <= '0;
            paddr_q      <= '0;
            level_q      <= LVL_DIR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        base_q  <= table_base;
                    end
                end
                ST_OUTER: begin
                    if (mem_rvalid) begin
                        leaf_frame_q <= rd_frame;
                        level_q      <= LVL_DIR;
                    end
                end
                ST_INNER: begin
                    if (mem_rvalid) begin
                        paddr_q <= {rd_frame, vaddr_q[OFF_W-1:0]};
                        level_q <= LVL_LEAF;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready        = 1'b0;
        mem_req          = 1'b0;
        mem_addr         = '0;
        resp_valid       = 1'b0;
        resp_paddr       = '0;
        resp_fault       = 1'b0;
        resp_fault_level = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_OUTER: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            ST_INNER: begin
                mem_req  = 1'b1;
                mem_addr = leaf_addr;
            end
            ST_DONE: begin
                resp_valid = 1'b1;
                resp_paddr = paddr_q;
            end
            ST_FAULT: begin
                resp_valid       = 1'b1;
                resp_fault       = 1'b1;
                resp_fault_level = level_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req,
    input logic            mem_rvalid,
    input logic [VA_W-1:0] mem_addr,
    input logic            resp_valid,
    input logic            resp_fault
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R4

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !resp_valid)); // R8

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready)); // R9

    AST_FAULT_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> resp_valid); // R6

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(mem_req && mem_rvalid)); // R5
endmodule

bind pgwalk_top pgwalk_chk #(.VA_W(VA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_rvalid(mem_rvalid),
    .mem_addr  (mem_addr),
    .resp_valid(resp_valid),
    .resp_fault(resp_fault)
);

// File: tb/pgwalk_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
    typedef struct packed {
        logic [31:0] vaddr;
        logic [31:0] base;
        logic [31:0] dir_pte;
        logic [31:0] leaf_pte;
        logic [3:0]  lat;
        logic [31:0] exp_paddr;
        logic        exp_fault;
        logic        exp_level;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0040_3ABC, 32'h0001_0000, 32'h0002_0001, 32'h1234_5001, 4'd0, 32'h1234_5ABC, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 32'h0008_0000, 32'h0003_1003, 32'h7654_3FFF, 4'd3, 32'h7654_3FFF, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h0000_1000, 32'h0000_5001, 32'h000A_B001, 4'd1, 32'h000A_B000, 1'b0, 1'b0},
        '{32'h1234_5678, 32'h0010_0000, 32'hABCD_E000, 32'h0000_0000, 4'd2, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h8000_1FFF, 32'h0000_0000, 32'h0004_4001, 32'h9999_9FFE, 4'd0, 32'h0000_0000, 1'b1, 1'b1},
        '{32'h003F_F123, 32'hFFFF_F000, 32'hC000_0001, 32'h0000_1001, 4'd5, 32'h0000_1123, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] table_base = '0;
    logic        req_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        resp_fault_level;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .table_base(table_base),
        .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_fault_level(resp_fault_level)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dir_addr_of(input vec_t v);
        return v.base + {20'd0, v.vaddr[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] leaf_addr_of(input vec_t v);
        return {v.dir_pte[31:12], 12'h000} + {20'd0, v.vaddr[21:12], 2'b00};
    endfunction

    // caller sits at a falling edge where the read is due
    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                         input int lat, input string tag);
        chk(mem_req === 1'b1, {tag, " mem_req"}, {31'd0, mem_req}, 32'd1);
        chk(mem_addr === exp_addr, {tag, " mem_addr"}, mem_addr, exp_addr);
        for (int i = 0; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            chk(mem_req === 1'b1 && mem_addr === exp_addr, "R4 hold",
                mem_addr, exp_addr);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = data;
        @(posedge clk); @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = 32'hDEAD_BEEF;
    endtask

    task automatic run_walk(input vec_t v, input bit poke);
        @(negedge clk);
        req_valid  = 1'b1;
        req_vaddr  = v.vaddr;
        table_base = v.base;
        @(posedge clk); @(negedge clk);
        req_valid  = poke;
        req_vaddr  = ~v.vaddr;
        table_base = 32'h5555_0000;
        if (poke) chk(req_ready === 1'b0, "R8 ready low when busy", {31'd0, req_ready}, 32'd0);
        serve(dir_addr_of(v), v.dir_pte, int'(v.lat), "R2");
        if (v.dir_pte[0])
            serve(leaf_addr_of(v), v.leaf_pte, int'(v.lat), "R3");
        req_valid = 1'b0;
        chk(resp_valid === 1'b1, "R5 resp_valid due", {31'd0, resp_valid}, 32'd1);
        chk(resp_fault === v.exp_fault, v.exp_fault ? "R6/R7 fault flag" : "R5 no fault",
            {31'd0, resp_fault}, {31'd0, v.exp_fault});
        if (v.exp_fault) begin
            chk(resp_fault_level === v.exp_level, v.exp_level ? "R7 level" : "R6 level",
                {31'd0, resp_fault_level}, {31'd0, v.exp_level});
            if (!v.exp_level)
                chk(mem_req === 1'b0, "R6 no second read", {31'd0, mem_req}, 32'd0);
        end
        chk(resp_paddr === v.exp_paddr, "R5 paddr", resp_paddr, v.exp_paddr);
        @(negedge clk);
        chk(resp_valid === 1'b0 && req_ready === 1'b1, "R9 pulse then ready",
            {30'd0, resp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && mem_req === 1'b0 && resp_valid === 1'b0, "R1 reset state",
            {29'd0, req_ready, mem_req, resp_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_req === 1'b0, "R1 idle after reset",
            {30'd0, req_ready, mem_req}, 32'd2);

        for (int k = 0; k < NVEC; k++) run_walk(VECS[k], 1'b0);

        // directed: request during walk ignored
        run_walk(VECS[1], 1'b1);
        run_walk(VECS[4], 1'b1);
        // directed: back-to-back zero-latency walk after fault
        run_walk(VECS[3], 1'b0);
        run_walk(VECS[0], 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule